// File: doc/BRIEF.md
# Bidirectional Row-Scan Shift Register

This block is the row-scan side of a wide LCD driver. It runs in a single system clock domain. It watches a slow scan strobe and, on every falling edge of that strobe, advances a register with one bit per output by one place. A direction input chooses which end of the register takes in new data and which end passes data on to the next device in a cascade. For each end pin the block provides an input, an output and an output enable.

A mode input decides how the register is arranged. It can be one long chain, or two half-length chains that advance together, with the upper half fed from its own data pin. Each register bit produces a 2-bit drive-level code for one output. The code combines the bit value with a frame-polarity input. An active-low blanking input forces every code to the lowest level, empties the register and stops shifting.

The strobe, the blanking input and the three serial data inputs pass through two-stage synchronisers before the block uses them. Direction, mode and frame polarity are treated as quasi-static controls and are used directly.

Top module: `scan_shift_reg`

## Requirements
- R1: The register moves by exactly one position for each falling edge of `lp_i`. Falling edges are detected after the two-stage synchroniser. A rising edge, or a strobe held at one level, leaves the register unchanged.
- R2: With `dir_i`=1 and `dual_i`=0, data moves toward higher outputs. Output 1 (bit 0) takes the synchronised `end_a_i`. `end_b_o` carries the bit of output NOUT.
- R3: With `dir_i`=0 and `dual_i`=0, data moves toward lower outputs. Output NOUT takes the synchronised `end_b_i`. `end_a_o` carries the bit of output 1.
- R4: With `dir_i`=1 and `dual_i`=1, output NOUT/2+1 (bit index NOUT/2) takes the synchronised `half_in_i` on each shift. Output 1 still takes `end_a_i`, and both halves advance on the same edge.
- R5: With `dir_i`=0 and `dual_i`=1, output NOUT/2 (bit index NOUT/2-1) takes the synchronised `half_in_i` on each shift. Output NOUT still takes `end_b_i`.
- R6: With `dual_i`=0, `half_in_i` has no effect. Bit NOUT/2 receives the bit from its neighbour, as in a single chain.
- R7: While the synchronised `blank_n_i` is 0, the following all hold: every level code is 0, the register is cleared to all zeros, and strobe edges cause no shift. After blanking is released, the outputs show an all-zero register.
- R8: When not blanked, output k (bits `level_o[2k-1:2k-2]`) is coded as follows. Frame 0 with bit 0 gives 1. Frame 0 with bit 1 gives 3. Frame 1 with bit 0 gives 2. Frame 1 with bit 1 gives 0.
- R9: `end_b_oe` is 1 and `end_a_oe` is 0 when `dir_i`=1. The reverse holds when `dir_i`=0.
- R10: During and right after reset, every level code is 0. Once blanking is released, the register reads as all zeros.

Each item is tagged R1 to R10 in the bench and the assertions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_i | input | 1 | Scan strobe; the register shifts on its falling edge |
| dir_i | input | 1 | 1: shift toward output NOUT; 0: shift toward output 1 |
| dual_i | input | 1 | 1: two half-length chains; 0: one chain |
| frame_i | input | 1 | Frame polarity used in level coding |
| blank_n_i | input | 1 | Active-low blanking |
| end_a_i | input | 1 | Serial data in at the output-1 end |
| end_a_o | output | 1 | Serial data out at the output-1 end |
| end_a_oe | output | 1 | Output enable for the output-1 end |
| end_b_i | input | 1 | Serial data in at the output-NOUT end |
| end_b_o | output | 1 | Serial data out at the output-NOUT end |
| end_b_oe | output | 1 | Output enable for the output-NOUT end |
| half_in_i | input | 1 | Data in for the upper half chain in dual mode |
| level_o | output | 2*NOUT | Level codes, 2 bits per output, output 1 in the lowest bits |

## Verification
The assertions assume that `dir_i` and `dual_i` stay constant across a strobe edge. They also assume that the serial inputs settle before the strobe falls, so that the synchronised data and the synchronised edge appear in the same cycle. The stimulus meets both assumptions. Each strobe level is held for four clocks. Data inputs change only together with the rising half of the strobe. Direction and mode change only while the strobe is low and no edge is in flight.

// File: rtl/scan_shift_reg.sv
module scan_shift_reg #(
  parameter int NOUT = 240,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_i,
  input  logic              dir_i,
  input  logic              dual_i,
  input  logic              frame_i,
  input  logic              blank_n_i,
  input  logic              end_a_i,
  output logic              end_a_o,
  output logic              end_a_oe,
  input  logic              end_b_i,
  output logic              end_b_o,
  output logic              end_b_oe,
  input  logic              half_in_i,
  output logic [2*NOUT-1:0] level_o
);
  localparam int HALF = NOUT / 2;

  logic [SYNC-1:0] lp_q, bl_q, a_q, b_q, h_q;
  logic            lp_d;
  logic [NOUT-1:0] chain, nxt;

  wire lp_s = lp_q[SYNC-1];
  wire bl_s = bl_q[SYNC-1];
  wire a_s  = a_q[SYNC-1];
  wire b_s  = b_q[SYNC-1];
  wire h_s  = h_q[SYNC-1];
  wire fall = lp_d & ~lp_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lp_q <= '0;
      bl_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      h_q  <= '0;
      lp_d <= 1'b0;
    end else begin
      lp_q <= {lp_q[SYNC-2:0], lp_i};
      bl_q <= {bl_q[SYNC-2:0], blank_n_i};
      a_q  <= {a_q[SYNC-2:0], end_a_i};
      b_q  <= {b_q[SYNC-2:0], end_b_i};
      h_q  <= {h_q[SYNC-2:0], half_in_i};
      lp_d <= lp_s;
    end
  end

  always_comb begin
    if (dir_i) begin
      nxt = {chain[NOUT-2:0], a_s};
      if (dual_i) nxt[HALF] = h_s;
    end else begin
      nxt = {b_s, chain[NOUT-1:1]};
      if (dual_i) nxt[HALF-1] = h_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !bl_s) chain <= '0;
    else if (fall)       chain <= nxt;
  end

  assign end_a_o  = chain[0];
  assign end_b_o  = chain[NOUT-1];
  assign end_a_oe = ~dir_i;
  assign end_b_oe = dir_i;

  for (genvar i = 0; i < NOUT; i++) begin : g_lvl
    assign level_o[2*i +: 2] = !bl_s   ? 2'd0 :
                               frame_i ? (chain[i] ? 2'd0 : 2'd2)
                                       : (chain[i] ? 2'd3 : 2'd1);
  end

  a_r1_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && bl_s) |=> $stable(chain));
  a_r2_entry_low_end: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && bl_s && dir_i) |=> chain[0] == $past(a_s));
  a_r3_entry_high_end: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && bl_s && !dir_i) |=> chain[NOUT-1] == $past(b_s));
  a_r4_half_entry_up: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && bl_s && dir_i && dual_i) |=> chain[HALF] == $past(h_s));
  a_r5_half_entry_down: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && bl_s && !dir_i && dual_i) |=> chain[HALF-1] == $past(h_s));
  a_r6_single_seam: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && bl_s && dir_i && !dual_i) |=> chain[HALF] == $past(chain[HALF-1]));
  a_r7_blank_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !bl_s |=> chain == '0);
endmodule

// File: tb/scan_shift_reg_bench.sv
module scan_shift_reg_bench;
  localparam int N = 240;
  localparam int H = N / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lp_i = 0, dir_i = 1, dual_i = 0, frame_i = 0, blank_n_i = 1;
  logic end_a_i = 0, end_b_i = 0, half_in_i = 0;
  logic end_a_o, end_a_oe, end_b_o, end_b_oe;
  logic [2*N-1:0] level_o;
  logic [N-1:0]   m = '0;
  int vectors = 0, fails = 0;

  always #10 clk = ~clk;

  scan_shift_reg #(.NOUT(N)) u_scan_shift_reg (
    .clk(clk), .rst_n(rst_n), .lp_i(lp_i), .dir_i(dir_i), .dual_i(dual_i),
    .frame_i(frame_i), .blank_n_i(blank_n_i),
    .end_a_i(end_a_i), .end_a_o(end_a_o), .end_a_oe(end_a_oe),
    .end_b_i(end_b_i), .end_b_o(end_b_o), .end_b_oe(end_b_oe),
    .half_in_i(half_in_i), .level_o(level_o));

  function automatic logic [2*N-1:0] exp_lv(logic [N-1:0] v, logic f, logic bl);
    logic [2*N-1:0] r;
    for (int i = 0; i < N; i++)
      r[2*i +: 2] = !bl ? 2'd0 : f ? (v[i] ? 2'd0 : 2'd2) : (v[i] ? 2'd3 : 2'd1);
    return r;
  endfunction

  function automatic logic pat(int k);
    return ((k * 5 + 3) % 7) > 3;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [2*N-1:0] act, exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic a, input logic b, input logic h, input logic blanked);
    end_a_i = a; end_b_i = b; half_in_i = h; lp_i = 1'b1;
    repeat (4) @(negedge clk);
    lp_i = 1'b0;
    repeat (4) @(negedge clk);
    if (!blanked) begin
      if (dir_i) begin
        m = {m[N-2:0], a};
        if (dual_i) m[H] = h;
      end else begin
        m = {b, m[N-1:1]};
        if (dual_i) m[H-1] = h;
      end
    end
  endtask

  task automatic chk_state(input string tag);
    chk(level_o == exp_lv(m, frame_i, 1'b1), tag, level_o, exp_lv(m, frame_i, 1'b1));
    if (dir_i) chk(end_b_o == m[N-1], {tag, " end_b_o"}, end_b_o, m[N-1]);
    else       chk(end_a_o == m[0], {tag, " end_a_o"}, end_a_o, m[0]);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(level_o == '0, "R10 in reset", level_o, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(level_o == exp_lv('0, 1'b0, 1'b1), "R10 after reset", level_o, exp_lv('0, 1'b0, 1'b1));
  endtask

  task automatic t_rise_only;
    lp_i = 1'b1; end_a_i = 1'b1;
    repeat (6) @(negedge clk);
    chk(level_o == exp_lv(m, 1'b0, 1'b1), "R1 rising edge no shift", level_o, exp_lv(m, 1'b0, 1'b1));
    lp_i = 1'b0;
    repeat (4) @(negedge clk);
    m = {m[N-2:0], 1'b1};
    chk(level_o == exp_lv(m, 1'b0, 1'b1), "R1 one shift per fall", level_o, exp_lv(m, 1'b0, 1'b1));
  endtask

  task automatic t_right_single;
    dir_i = 1; dual_i = 0;
    chk(end_b_oe && !end_a_oe, "R9 oe dir=1", {end_a_oe, end_b_oe}, 2'b01);
    for (int k = 0; k < N + 10; k++) begin
      pulse(pat(k), 1'b0, ~pat(k), 1'b0);
      chk_state("R2 R6 right single");
    end
  endtask

  task automatic t_left_single;
    dir_i = 0; dual_i = 0;
    @(negedge clk);
    chk(end_a_oe && !end_b_oe, "R9 oe dir=0", {end_a_oe, end_b_oe}, 2'b10);
    for (int k = 0; k < N + 10; k++) begin
      pulse(1'b0, pat(k + 2), pat(k), 1'b0);
      chk_state("R3 R6 left single");
    end
  endtask

  task automatic t_dual(input logic d);
    dir_i = d; dual_i = 1;
    @(negedge clk);
    for (int k = 0; k < H + 6; k++) begin
      pulse(pat(k), pat(k + 1), pat(k + 4), 1'b0);
      chk_state(d ? "R4 dual right" : "R5 dual left");
    end
  endtask

  task automatic t_levels;
    frame_i = 1'b1;
    @(negedge clk);
    chk(level_o == exp_lv(m, 1'b1, 1'b1), "R8 frame=1 codes", level_o, exp_lv(m, 1'b1, 1'b1));
    frame_i = 1'b0;
    @(negedge clk);
    chk(level_o == exp_lv(m, 1'b0, 1'b1), "R8 frame=0 codes", level_o, exp_lv(m, 1'b0, 1'b1));
  endtask

  task automatic t_blank;
    blank_n_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(level_o == '0, "R7 blanked levels", level_o, '0);
    pulse(1'b1, 1'b1, 1'b1, 1'b1);
    chk(level_o == '0, "R7 no shift while blanked", level_o, '0);
    blank_n_i = 1'b1;
    repeat (4) @(negedge clk);
    m = '0;
    chk(level_o == exp_lv(m, 1'b0, 1'b1), "R7 register cleared", level_o, exp_lv(m, 1'b0, 1'b1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_rise_only();
    t_right_single();
    t_levels();
    t_left_single();
    t_dual(1'b1);
    t_dual(1'b0);
    t_levels();
    t_blank();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule